// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This controller burns a block of bytes into an external, ultraviolet-erasable parallel EPROM. Bytes arrive on a valid/ready stream. Each accepted byte is written to one address. The first byte of a block goes to `base_addr` and each later byte goes to the address after the previous one. For every byte the sequencer raises the high-voltage supply request and holds output enable inactive. It drives address and data, then strobes chip enable low for one fixed-width program pulse. After the pulse it releases the data bus and reads the location back. It repeats pulse and read-back until the cell returns the wanted value. When the read-back matches, it moves on at once and applies no extra margin pulse.

An erased cell reads all ones, and a pulse can only clear bits. A read-back that shows a 0 where the target byte has a 1 therefore cannot be repaired. The sequencer reports that case as unprogrammable right away. A byte that still does not match after `MAX_PULSES` pulses is reported as a retry-limit failure. In both failure cases the failing address is kept, and the sequencer returns to idle.

Back-pressure works as follows. `in_ready` is high only while the sequencer is idle, and a byte is taken on a cycle where `in_valid` and `in_ready` are both high. While a byte is being programmed, `in_ready` stays low, and the source must hold its byte and `in_last` until the transfer completes. The data bus is split into an output, an output enable and an input, and an external pad joins them into one tri-state bus.

The program pulse is `PULSE_CYC` = (`CLK_HZ`/1,000,000)·`PULSE_US` clock cycles long.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, `in_ready`=1, `ep_ce_n`=1, `ep_oe_n`=1, `ep_vpp_en`=0, `ep_data_oe`=0, `byte_ok`=0, `done`=0, `err`=0 and `err_unprog`=0.
- R2: `in_ready` is high only while idle, with `ep_ce_n`=1 and `ep_vpp_en`=0. A byte is accepted when `in_valid` and `in_ready` are both high. The first byte after reset, after `done` or after an error goes to `base_addr`, and each later byte goes to the previous address plus 1.
- R3: `ep_vpp_en` is high from acceptance until the byte's outcome. Each program pulse holds `ep_ce_n` low for exactly `PULSE_CYC` cycles, with `ep_oe_n`=1 and the data bus driven.
- R4: Address and data are driven for at least `SETUP_CYC` cycles before `ep_ce_n` falls and for at least `HOLD_CYC` cycles after it rises. The address does not change while `ep_ce_n` is low.
- R5: After each pulse the data bus is released for `SETUP_CYC` cycles. Then `ep_ce_n` and `ep_oe_n` are both low for `ACCESS_CYC` cycles, and the read-back is sampled in the last of those cycles. `ep_data_oe` is never high while `ep_oe_n` is low.
- R6: When the read-back equals the target byte, `byte_ok` pulses for one cycle and `byte_pulses` equals the number of pulses applied to that address. No further pulse goes to that address, so a byte already holding its target gets exactly 1 pulse.
- R7: If (target AND NOT read-back) is nonzero, `err` and `err_unprog` rise and `err_addr` takes the address, with no further pulse.
- R8: If `MAX_PULSES` pulses have been applied without a match, `err`=1, `err_unprog`=0 and `err_addr` takes the address. Exactly `MAX_PULSES` pulses reach that address. A match on the `MAX_PULSES`-th pulse is a success.
- R9: `done` pulses for one cycle, in the same cycle as `byte_ok`, only for a byte accepted with `in_last`=1.
- R10: `err` and `err_unprog` hold until the next byte is accepted and clear on acceptance. After an error, `in_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | AW | Start address of the next block |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Sequencer can accept a byte |
| in_data | input | DW | Byte to program |
| in_last | input | 1 | Byte is the last of its block |
| ep_addr | output | AW | EPROM address bus |
| ep_data_o | output | DW | Data driven toward the EPROM |
| ep_data_oe | output | 1 | Drive enable for `ep_data_o` |
| ep_data_i | input | DW | Data read from the EPROM bus |
| ep_ce_n | output | 1 | Chip enable, active low |
| ep_oe_n | output | 1 | Output enable, active low |
| ep_vpp_en | output | 1 | Request for the programming supply |
| byte_ok | output | 1 | One-cycle pulse: byte verified |
| byte_pulses | output | PW | Pulses applied to the current or last byte |
| done | output | 1 | One-cycle pulse: last byte of block verified |
| err | output | 1 | Byte failed; held until next acceptance |
| err_unprog | output | 1 | Failure was a 1 requested over a programmed 0 |
| err_addr | output | AW | Address of the failing byte |

## Verification
Two decisions can land on the same read-back: the cell can match on the very pulse that uses up the retry budget. The bench provokes this by giving the memory stub cells that need exactly `MAX_PULSES` pulses and cells that need one more. The first must end in `byte_ok` with `byte_pulses` equal to `MAX_PULSES`, and the second in a retry-limit error after exactly `MAX_PULSES` pulses. The bench also checks that `byte_ok` and `done` fall in the same cycle on the last byte of each block, and only on that byte.

// File: rtl/eprog_pkg.sv
package eprog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_READ,
    ST_JUDGE
  } eprog_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eprog_timer.sv
// Down-counting phase timer: loaded with (length-1), reports the last cycle.
module eprog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprog_judge.sv
// Read-back evaluation: exact match, or a bit that can never be raised again.
module eprog_judge #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] want,
  input  logic [DW-1:0] seen,
  output logic          match,
  output logic          stuck
);
  assign match = (want == seen);
  assign stuck = |(want & ~seen);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprog_pkg::*;
#(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int CLK_HZ     = 100_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int ACCESS_CYC = 3,
  localparam int PW        = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic [AW-1:0] ep_addr,
  output logic [DW-1:0] ep_data_o,
  output logic          ep_data_oe,
  input  logic [DW-1:0] ep_data_i,
  output logic          ep_ce_n,
  output logic          ep_oe_n,
  output logic          ep_vpp_en,
  output logic          byte_ok,
  output logic [PW-1:0] byte_pulses,
  output logic          done,
  output logic          err,
  output logic          err_unprog,
  output logic [AW-1:0] err_addr
);
  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int LONGEST   = imax(imax(PULSE_CYC, ACCESS_CYC), imax(SETUP_CYC, HOLD_CYC));
  localparam int TW        = $clog2(LONGEST + 1);

  eprog_state_e  st_q, nxt;
  logic          ld, tmr_exp, take, match, stuck;
  logic [TW-1:0] ldv;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] tgt_q, rd_q;
  logic          last_q, fresh_q;
  logic [PW-1:0] pcnt_q;

  eprog_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .expired(tmr_exp)
  );

  eprog_judge #(.DW(DW)) u_judge (
    .want(tgt_q), .seen(rd_q), .match(match), .stuck(stuck)
  );

  assign in_ready    = (st_q == ST_IDLE);
  assign take        = in_valid && in_ready;
  assign ep_addr     = addr_q;
  assign ep_data_o   = tgt_q;
  assign byte_pulses = pcnt_q;

  always_comb begin
    nxt = st_q;
    ld  = 1'b0;
    ldv = '0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        nxt = ST_SETUP; ld = 1'b1; ldv = TW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_exp) begin
        nxt = ST_PULSE; ld = 1'b1; ldv = TW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_exp) begin
        nxt = ST_HOLD; ld = 1'b1; ldv = TW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_exp) begin
        nxt = ST_TURN; ld = 1'b1; ldv = TW'(SETUP_CYC - 1);
      end
      ST_TURN: if (tmr_exp) begin
        nxt = ST_READ; ld = 1'b1; ldv = TW'(ACCESS_CYC - 1);
      end
      ST_READ: if (tmr_exp) nxt = ST_JUDGE;
      ST_JUDGE: begin
        if (match || stuck || pcnt_q == PW'(MAX_PULSES)) begin
          nxt = ST_IDLE;
        end else begin
          nxt = ST_SETUP; ld = 1'b1; ldv = TW'(SETUP_CYC - 1);
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      tgt_q      <= '1;
      rd_q       <= '1;
      last_q     <= 1'b0;
      fresh_q    <= 1'b1;
      pcnt_q     <= '0;
      ep_ce_n    <= 1'b1;
      ep_oe_n    <= 1'b1;
      ep_data_oe <= 1'b0;
      ep_vpp_en  <= 1'b0;
      byte_ok    <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_unprog <= 1'b0;
      err_addr   <= '0;
    end else begin
      st_q       <= nxt;
      byte_ok    <= 1'b0;
      done       <= 1'b0;
      // strobes are registered decodes of the next phase: glitch-free pins
      ep_ce_n    <= !(nxt == ST_PULSE || nxt == ST_READ);
      ep_oe_n    <= !(nxt == ST_READ);
      ep_data_oe <= (nxt == ST_SETUP) || (nxt == ST_PULSE) || (nxt == ST_HOLD);
      ep_vpp_en  <= (nxt != ST_IDLE);
      if (take) begin
        tgt_q      <= in_data;
        last_q     <= in_last;
        addr_q     <= fresh_q ? base_addr : addr_q + 1'b1;
        fresh_q    <= 1'b0;
        pcnt_q     <= '0;
        err        <= 1'b0;
        err_unprog <= 1'b0;
      end
      if (st_q == ST_SETUP && tmr_exp) pcnt_q <= pcnt_q + 1'b1;
      if (st_q == ST_READ && tmr_exp)  rd_q   <= ep_data_i;
      if (st_q == ST_JUDGE) begin
        if (match) begin
          byte_ok <= 1'b1;
          if (last_q) begin
            done    <= 1'b1;
            fresh_q <= 1'b1;
          end
        end else if (stuck) begin
          err        <= 1'b1;
          err_unprog <= 1'b1;
          err_addr   <= addr_q;
          fresh_q    <= 1'b1;
        end else if (pcnt_q == PW'(MAX_PULSES)) begin
          err      <= 1'b1;
          err_addr <= addr_q;
          fresh_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int AW         = 15,
  parameter int PW         = 5,
  parameter int MAX_PULSES = 25,
  parameter int PULSE_CYC  = 10000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [AW-1:0] ep_addr,
  input logic          ep_data_oe,
  input logic          ep_ce_n,
  input logic          ep_oe_n,
  input logic          ep_vpp_en,
  input logic          byte_ok,
  input logic [PW-1:0] byte_pulses,
  input logic          done,
  input logic          err,
  input logic          err_unprog
);
  localparam int CW = $clog2(PULSE_CYC + 2) + 1;
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_run <= '0;
    else if (!ep_ce_n && ep_oe_n) low_run <= low_run + 1'b1;
    else                          low_run <= '0;
  end

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(ep_data_oe && !ep_oe_n));
  a_r3_pulse_in_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_ce_n && ep_oe_n) |-> (ep_vpp_en && ep_data_oe));
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ep_ce_n) && $past(ep_oe_n)) |-> (low_run == CW'(PULSE_CYC)));
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_ce_n && $past(!ep_ce_n)) |-> $stable(ep_addr));
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (ep_ce_n && !ep_vpp_en));
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok |-> (byte_pulses >= PW'(1) && byte_pulses <= PW'(MAX_PULSES)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> byte_ok);
  a_r7_unprog_is_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_unprog |-> err);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .AW(AW), .PW(PW), .MAX_PULSES(MAX_PULSES), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ep_addr(ep_addr),
  .ep_data_oe(ep_data_oe), .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n),
  .ep_vpp_en(ep_vpp_en), .byte_ok(byte_ok), .byte_pulses(byte_pulses),
  .done(done), .err(err), .err_unprog(err_unprog)
);

// File: tb/eprom_prog_seq_test.sv
`timescale 1ns/1ps
module eprom_prog_seq_test;
  localparam int AW = 4, DW = 8, MAXP = 6, SU = 2, HO = 2, ACC = 3;
  localparam int CLKHZ = 1_000_000, PUS = 100;
  localparam int PCYC = (CLKHZ / 1_000_000) * PUS;
  localparam int PW = $clog2(MAXP + 1);
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] base_addr = '0;
  logic in_valid = 0, in_last = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, ep_data_oe, ep_ce_n, ep_oe_n, ep_vpp_en;
  logic byte_ok, done, err, err_unprog;
  logic [AW-1:0] ep_addr, err_addr;
  logic [DW-1:0] ep_data_o, ep_data_i;
  logic [PW-1:0] byte_pulses;

  always #5 clk = ~clk;

  eprom_prog_seq #(.AW(AW), .DW(DW), .CLK_HZ(CLKHZ), .PULSE_US(PUS), .MAX_PULSES(MAXP),
                   .SETUP_CYC(SU), .HOLD_CYC(HO), .ACCESS_CYC(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .ep_addr(ep_addr),
    .ep_data_o(ep_data_o), .ep_data_oe(ep_data_oe), .ep_data_i(ep_data_i),
    .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n), .ep_vpp_en(ep_vpp_en), .byte_ok(byte_ok),
    .byte_pulses(byte_pulses), .done(done), .err(err), .err_unprog(err_unprog),
    .err_addr(err_addr));

  // behavioural memory stub: a cell clears bits once it has seen need[] pulses
  logic [DW-1:0] mem [N];
  int need [N];
  int pc [N];
  assign ep_data_i = (!ep_ce_n && !ep_oe_n) ? mem[ep_addr] : 8'hFF;

  int n_cmp = 0, n_bad = 0;
  int plow = 0, drv_run = 0, rel_run = 0, held = 0, npulse = 0;
  int pw_err = 0, su_err = 0, ho_err = 0, ta_err = 0, bus_err = 0;
  logic prev_ce = 1, prev_oe = 1, prev_doe = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ep_data_oe && !ep_oe_n) bus_err++;
      if (!ep_ce_n && ep_oe_n && !ep_vpp_en) bus_err++;
      if (!ep_ce_n && ep_oe_n && prev_ce && drv_run < SU) su_err++;
      if (prev_oe && !ep_oe_n && rel_run < SU) ta_err++;
      if (prev_doe && !ep_data_oe && held < HO) ho_err++;
      if (!prev_ce && ep_ce_n && prev_oe) begin
        pc[ep_addr]++;
        if (pc[ep_addr] >= need[ep_addr]) mem[ep_addr] &= ep_data_o;
      end
      if (!ep_ce_n && ep_oe_n) plow++;
      else begin
        if (plow != 0) begin
          npulse++;
          if (plow != PCYC) pw_err++;
          held = 0;
        end
        plow = 0;
      end
      if (ep_ce_n && ep_data_oe) held++;
      drv_run = ep_data_oe ? drv_run + 1 : 0;
      rel_run = ep_data_oe ? 0 : rel_run + 1;
    end
    prev_ce = ep_ce_n; prev_oe = ep_oe_n; prev_doe = ep_data_oe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // program one byte at expected address a; expectations from R6/R7/R8/R9
  task automatic do_byte(input int a, input logic [7:0] d, input bit last);
    logic [7:0] init;
    int kind, exp_n, waitc;
    bit got_ok, got_err, got_done, early;
    init = mem[a];
    if ((d & ~init) != 0)   begin kind = 1; exp_n = 1; end
    else if (init == d)     begin kind = 0; exp_n = 1; end
    else if (need[a] > MAXP) begin kind = 2; exp_n = MAXP; end
    else                    begin kind = 0; exp_n = need[a]; end
    pc[a] = 0;
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    check(err == 0, "R10", "err cleared on accept", err, 0);
    early = 0; waitc = 0;
    while (!(byte_ok || err) && waitc < 5000) begin
      if (in_ready) early = 1;
      @(negedge clk); waitc++;
    end
    check(waitc < 5000, "R6", "outcome before timeout", waitc, 5000);
    check(!early, "R2", "in_ready low while busy", early, 0);
    got_ok = byte_ok; got_err = err; got_done = done;
    check(pc[a] == exp_n, "R2", "pulses seen at expected address", pc[a], exp_n);
    if (kind == 0) begin
      check(got_ok && !got_err, "R6", "byte_ok on match", got_ok, 1);
      check(int'(byte_pulses) == exp_n, "R6", "byte_pulses", byte_pulses, exp_n);
      check(mem[a] == d, "R6", "cell content", mem[a], d);
      check(got_done == last, "R9", "done only on last byte", got_done, last);
    end else begin
      check(got_err && !got_ok, "R8", "error raised", got_err, 1);
      check(err_unprog == (kind == 1), kind == 1 ? "R7" : "R8", "err_unprog",
            err_unprog, kind == 1);
      check(int'(err_addr) == a, kind == 1 ? "R7" : "R8", "err_addr", err_addr, a);
      check(!got_done, "R9", "no done on error", got_done, 0);
      @(negedge clk);
      check(err && in_ready, "R10", "err held and ready", {err, in_ready}, 3);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mem[i] = 8'hFF; need[i] = 1; pc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && ep_ce_n && ep_oe_n && !ep_vpp_en && !ep_data_oe, "R1",
          "idle pins", {in_ready, ep_ce_n, ep_oe_n, ep_vpp_en, ep_data_oe}, 5'b11100);
    check(!byte_ok && !done && !err && !err_unprog, "R1", "status low",
          {byte_ok, done, err, err_unprog}, 0);

    // full sweep of the address space, 1..5 pulses per cell
    base_addr = 0;
    for (int a = 0; a < N; a++) begin
      need[a] = (a % 5) + 1;
      do_byte(a, 8'(a * 29) ^ 8'h5A, a == N - 1);
    end

    // boundary: match on the last allowed pulse, then one pulse too many (R8)
    for (int i = 0; i < N; i++) mem[i] = 8'hFF;
    need[3] = MAXP;
    base_addr = 3;
    do_byte(3, 8'h81, 1);
    need[5] = MAXP + 1;
    base_addr = 5;
    do_byte(5, 8'h42, 1);

    // unprogrammable: 1 wanted over a programmed 0 (R7)
    mem[7] = 8'h0F;
    base_addr = 7;
    do_byte(7, 8'hF0, 1);

    // already holds target: one pulse only, then next address (R6, R2)
    mem[9] = 8'h3C; need[9] = 4; need[10] = 3;
    base_addr = 9;
    do_byte(9, 8'h3C, 0);
    base_addr = 0;
    do_byte(10, 8'hA5, 1);

    check(npulse > 0 && pw_err == 0, "R3", "pulse width errors", pw_err, 0);
    check(su_err == 0 && ho_err == 0, "R4", "setup/hold errors", su_err + ho_err, 0);
    check(ta_err == 0 && bus_err == 0, "R5", "turnaround/bus errors", ta_err + bus_err, 0);
    summary();
  end

  initial begin
    #1_900_000;
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule